// File: doc/BRIEF.md
# Receive Octet Slip Buffer

This block sits between a 64 kbit/s line decoder and a 2.048 Mbit/s PCM bus. Decoded bits arrive serially on the recovered clock, together with a strobe that marks the final bit of each octet. Each finished octet is parked in one of two holding registers. The local PCM clock reads these registers one at a time and sends each one as an eight-bit serial burst inside a chosen time slot.

The two clocks are not locked together, so the rates drift apart over time. Slips are always made in whole octets:

- When the PCM side falls behind and both registers are still unread, the newly completed octet is discarded.
- When the PCM side runs ahead and no fresh octet is waiting, the last octet sent is sent again.

Handoff between the clock domains uses per-register toggle flags passed through synchronizers. A register is never written while its flag says it is waiting to be read.

The output is driven from a flop and idles high. Two sources force it to all ones:

- an external blank input, in the PCM domain;
- a blank request from the decoder, in the line domain, which is synchronized before use.

Top module: `rx_slip_buffer`

## Requirements
- R1: After reset the PCM output is high. A slot that arrives before any octet has been stored sends all ones.
- R2: Slot select high makes `slot_a` the active envelope, and select low makes `slot_b` the active envelope. Activity on the envelope that is not selected leaves the output high and leaves stored octets unread.
- R3: Let E be the first rising PCM clock edge at which the selected envelope is sampled high. Bit k of the burst appears on `pcm_out` after edge E+k, for k = 0 to 7.
- R4: The output is high after every edge at which the selected envelope is sampled low. It is also high after the eighth bit of a burst while the envelope stays high.
- R5: Octets are sent in the order they were received. Bit 0 of a burst is the earliest received bit of that octet.
- R6: If no new octet has become ready since the previous burst, the previous burst's octet is sent again.
- R7: An octet whose strobe arrives while both holding registers are still unread is discarded. The two held octets are sent in order, and then the second one repeats.
- R8: While `blank_ext` is high, the output after each PCM clock edge is high. The octet due in that slot is still consumed.
- R9: A high `wr_blank_req` forces the output high once it has passed through the synchronizer. The octet due in that slot is still consumed.
- R10: The stored octet is the last eight valid bits up to and including the bit that carries the strobe. Bits received before that are ignored.
- R11: A holding register does not change while it is waiting to be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered line clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, line domain |
| wr_bit | input | 1 | Decoded data bit |
| wr_bit_vld | input | 1 | `wr_bit` is valid this cycle |
| wr_octet_end | input | 1 | This valid bit is the last bit of its octet |
| wr_blank_req | input | 1 | Decoder request to blank the PCM output |
| rd_clk | input | 1 | Local 2.048 MHz PCM clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, PCM domain |
| slot_a | input | 1 | Time-slot envelope A |
| slot_b | input | 1 | Time-slot envelope B |
| slot_sel | input | 1 | 1 selects `slot_a`, 0 selects `slot_b` |
| blank_ext | input | 1 | Forces the PCM output to ones |
| pcm_out | output | 1 | Registered serial PCM data |

## Verification
Some properties are checked on every cycle by the assertions:
- the output is high outside the selected envelope, after the end of a burst, and under external blanking;
- a register waiting to be read never changes;
- a strobe that arrives while both registers are occupied publishes nothing;
- at most one release flag toggles per cycle, and none toggles when an octet is repeated.

Other behaviour only the bench scenarios can show:
- which octet ends up in which burst, and in what order;
- the drop-then-repeat pattern of a delete;
- the bit order and exact timing of a burst;
- the effect of stray bits before a strobe, and of the unselected envelope;
- the synchronized decoder blank.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
   // Number of holding registers in the elastic store
   localparam int NREG = 2;
   typedef logic [NREG-1:0] tgl_t;
endpackage

// File: rtl/rsb_sync.sv
module rsb_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rsb_wr_side.sv
module rsb_wr_side import rsb_pkg::*; #(
   parameter int OCT_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bit_i,
   input  logic                       bit_vld,
   input  logic                       oct_end,
   input  tgl_t                       ack_s,
   output tgl_t                       pub_q,
   output logic [NREG-1:0][OCT_W-1:0] regs_q
);
   logic [OCT_W-1:0] asm_q;
   logic [OCT_W-1:0] nxt_oct;
   logic             ptr_q;
   tgl_t             full;
   logic             commit;

   // A register is occupied while its publish flag differs from the returned release flag
   assign full    = pub_q ^ ack_s;
   // Newest bit enters at the top, so the earliest bit ends up in bit 0
   assign nxt_oct = {bit_i, asm_q[OCT_W-1:1]};
   assign commit  = bit_vld && oct_end && !full[ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asm_q  <= '0;
         ptr_q  <= 1'b0;
         pub_q  <= '0;
         regs_q <= '0;
      end else begin
         if (bit_vld) asm_q <= nxt_oct;
         if (commit) begin
            regs_q[ptr_q] <= nxt_oct;
            pub_q[ptr_q]  <= ~pub_q[ptr_q];
            ptr_q         <= ~ptr_q;
         end
      end
   end

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_hold
         AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n) full[g] |=> $stable(regs_q[g])); // R11
      end
   endgenerate

   AST_DROP_WHEN_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_n) (bit_vld && oct_end && (&full)) |=> $stable(pub_q)); // R7
endmodule

// File: rtl/rsb_rd_side.sv
module rsb_rd_side import rsb_pkg::*; #(
   parameter int OCT_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       slot,
   input  logic                       blank,
   input  tgl_t                       pub_s,
   input  logic [NREG-1:0][OCT_W-1:0] regs,
   output tgl_t                       ack_q,
   output logic                       pcm_out
);
   localparam int CW = $clog2(OCT_W + 1);

   logic             slot_q;
   logic             ptr_q;
   logic [OCT_W-1:0] last_q;
   logic [OCT_W-1:0] sh_q;
   logic [CW-1:0]    cnt_q;
   tgl_t             ready;
   logic             start;
   logic             fresh;
   logic [OCT_W-1:0] cur;
   logic             out_bit;

   assign ready = pub_s ^ ack_q;
   assign start = slot && !slot_q;
   assign fresh = ready[ptr_q];
   assign cur   = fresh ? regs[ptr_q] : last_q;

   always_comb begin
      if (start)                     out_bit = cur[0];
      else if (slot && cnt_q != '0)  out_bit = sh_q[0];
      else                           out_bit = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q  <= 1'b0;
         ptr_q   <= 1'b0;
         last_q  <= '1;
         sh_q    <= '1;
         cnt_q   <= '0;
         ack_q   <= '0;
         pcm_out <= 1'b1;
      end else begin
         slot_q  <= slot;
         pcm_out <= blank | out_bit;
         if (start) begin
            sh_q   <= cur >> 1;
            cnt_q  <= CW'(OCT_W - 1);
            last_q <= cur;
            if (fresh) begin
               ack_q[ptr_q] <= ~ack_q[ptr_q];
               ptr_q        <= ~ptr_q;
            end
         end else if (slot && cnt_q != '0) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !slot |=> pcm_out); // R4
   AST_TAIL_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (slot && slot_q && cnt_q == '0) |=> pcm_out); // R4
   AST_BLANK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) blank |=> pcm_out); // R8
   AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $countones(ack_q ^ $past(ack_q)) <= 1); // R5
   AST_REPEAT_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (start && !fresh) |=> $stable(ack_q)); // R6
endmodule

// File: rtl/rx_slip_buffer.sv
module rx_slip_buffer import rsb_pkg::*; #(
   parameter int OCT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic wr_clk,
   input  logic wr_rst_n,
   input  logic wr_bit,
   input  logic wr_bit_vld,
   input  logic wr_octet_end,
   input  logic wr_blank_req,
   input  logic rd_clk,
   input  logic rd_rst_n,
   input  logic slot_a,
   input  logic slot_b,
   input  logic slot_sel,
   input  logic blank_ext,
   output logic pcm_out
);
   initial begin : p_param_chk
      assert (OCT_W >= 2) else $error("OCT_W must be at least 2");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   tgl_t                       pub_q;
   tgl_t                       pub_s;
   tgl_t                       ack_q;
   tgl_t                       ack_s;
   logic [NREG-1:0][OCT_W-1:0] regs_q;
   logic                       blank_req_s;
   logic                       slot;
   logic                       blank;

   assign slot  = slot_sel ? slot_a : slot_b;
   assign blank = blank_ext | blank_req_s;

   rsb_wr_side #(.OCT_W(OCT_W)) u_wr (
      .clk(wr_clk), .rst_n(wr_rst_n), .bit_i(wr_bit), .bit_vld(wr_bit_vld),
      .oct_end(wr_octet_end), .ack_s(ack_s), .pub_q(pub_q), .regs_q(regs_q)
   );

   rsb_sync #(.W(NREG), .STAGES(SYNC_STAGES)) u_pub_sync (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(pub_q), .q(pub_s)
   );

   rsb_sync #(.W(NREG), .STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(ack_q), .q(ack_s)
   );

   rsb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_blank_sync (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_blank_req), .q(blank_req_s)
   );

   rsb_rd_side #(.OCT_W(OCT_W)) u_rd (
      .clk(rd_clk), .rst_n(rd_rst_n), .slot(slot), .blank(blank),
      .pub_s(pub_s), .regs(regs_q), .ack_q(ack_q), .pcm_out(pcm_out)
   );
endmodule

// File: tb/rx_slip_buffer_tb_top.sv
module rx_slip_buffer_tb_top;
   logic wr_clk = 1'b0;
   logic rd_clk = 1'b0;
   always #5 wr_clk = ~wr_clk;
   always #2 rd_clk = ~rd_clk;   // 250 MHz

   logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic wr_bit = 1'b0, wr_bit_vld = 1'b0, wr_octet_end = 1'b0, wr_blank_req = 1'b0;
   logic slot_a = 1'b0, slot_b = 1'b0, slot_sel = 1'b1, blank_ext = 1'b0;
   logic pcm_out;

   rx_slip_buffer dut_i (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_bit(wr_bit), .wr_bit_vld(wr_bit_vld),
      .wr_octet_end(wr_octet_end), .wr_blank_req(wr_blank_req),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .slot_a(slot_a), .slot_b(slot_b),
      .slot_sel(slot_sel), .blank_ext(blank_ext), .pcm_out(pcm_out)
   );

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: collects each burst and compares it with the scoreboard
   logic       sel_seen = 1'b0;
   int         nb = 0;
   logic [7:0] got = '0;
   logic [7:0] e;
   string      t;
   always @(posedge rd_clk) sel_seen <= rd_rst_n && (slot_sel ? slot_a : slot_b);
   always @(negedge rd_clk) begin
      if (sel_seen) begin
         if (nb < 8) begin
            got[nb] = pcm_out;
            nb++;
            if (nb == 8) begin
               if (exp_q.size() == 0) chk(1'b0, "R5 unexpected burst", got, 8'h00);
               else begin
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  chk(got === e, t, got, e);
               end
            end
         end
      end else if (nb == 8) begin
         chk(pcm_out === 1'b1, "R4 idle after burst", {7'b0, pcm_out}, 8'h01);
         nb = 0;
      end
   end

   task automatic send_octet(input logic [7:0] d);
      for (int i = 0; i < 8; i++) begin
         @(negedge wr_clk);
         wr_bit = d[i]; wr_bit_vld = 1'b1; wr_octet_end = (i == 7);
      end
      @(negedge wr_clk);
      wr_bit_vld = 1'b0; wr_octet_end = 1'b0;
   endtask

   task automatic send_junk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge wr_clk);
         wr_bit = i[0]; wr_bit_vld = 1'b1; wr_octet_end = 1'b0;
      end
      @(negedge wr_clk);
      wr_bit_vld = 1'b0;
   endtask

   task automatic wait_rd(input int n);
      repeat (n) @(negedge rd_clk);
   endtask

   task automatic burst(input logic sel, input logic [7:0] ex, input string tag);
      exp_q.push_back(ex);
      tag_q.push_back(tag);
      @(negedge rd_clk);
      slot_sel = sel;
      if (sel) slot_a = 1'b1; else slot_b = 1'b1;
      repeat (8) @(negedge rd_clk);
      slot_a = 1'b0; slot_b = 1'b0;
      repeat (4) @(negedge rd_clk);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      wait_rd(5);
      wr_rst_n = 1'b1; rd_rst_n = 1'b1;
      wait_rd(3);
      // R1: idle output after reset, then an empty store sends ones
      chk(pcm_out === 1'b1, "R1 reset output", {7'b0, pcm_out}, 8'h01);
      burst(1'b1, 8'hFF, "R1 burst before any octet");

      // R3 R5: one octet, bit 0 first, exact burst timing
      send_octet(8'hA5); wait_rd(20);
      burst(1'b1, 8'hA5, "R3 R5 single octet");
      // R6: nothing new, repeat
      burst(1'b1, 8'hA5, "R6 repeat last octet");

      // R2 R5: two octets via envelope B
      send_octet(8'h3C); send_octet(8'h81); wait_rd(20);
      burst(1'b0, 8'h3C, "R2 R5 slot B first octet");
      burst(1'b0, 8'h81, "R2 R5 slot B second octet");
      wait_rd(20);

      // R7: third octet arrives with both registers unread
      send_octet(8'h11); send_octet(8'h22); send_octet(8'h33); wait_rd(20);
      burst(1'b1, 8'h11, "R7 delete keeps oldest");
      burst(1'b1, 8'h22, "R7 delete keeps second");
      burst(1'b1, 8'h22, "R7 dropped octet absent, repeat");
      wait_rd(20);

      // R10: stray bits before a clean octet
      send_junk(3); send_octet(8'h5A); wait_rd(20);
      burst(1'b1, 8'h5A, "R10 strobe alignment");
      wait_rd(20);

      // R8: external blank consumes the octet
      send_octet(8'hC3); wait_rd(20);
      blank_ext = 1'b1;
      burst(1'b1, 8'hFF, "R8 external blank");
      blank_ext = 1'b0;
      burst(1'b1, 8'hC3, "R8 octet consumed during blank, repeat");
      wait_rd(20);

      // R9: decoder blank request through the synchronizer
      @(negedge wr_clk); wr_blank_req = 1'b1;
      send_octet(8'h96); wait_rd(20);
      burst(1'b1, 8'hFF, "R9 decoder blank");
      @(negedge wr_clk); wr_blank_req = 1'b0;
      wait_rd(20);
      burst(1'b1, 8'h96, "R9 octet consumed during blank, repeat");
      wait_rd(20);

      // R2: unselected envelope must not read or drive
      send_octet(8'hE7); wait_rd(20);
      begin
         logic stray_ok;
         stray_ok = 1'b1;
         @(negedge rd_clk); slot_sel = 1'b1; slot_b = 1'b1;
         for (int i = 0; i < 10; i++) begin
            @(negedge rd_clk);
            if (i == 7) slot_b = 1'b0;
            if (pcm_out !== 1'b1) stray_ok = 1'b0;
         end
         chk(stray_ok, "R2 unselected envelope ignored", {7'b0, stray_ok}, 8'h01);
      end
      burst(1'b1, 8'hE7, "R2 octet still pending after stray slot");

      wait_rd(10);
      chk(exp_q.size() == 0, "R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
      finish_run();
   end
endmodule